// File: doc/BRIEF.md
# Rate-Adjustable Precision Time Clock

This block keeps a 64-bit time count in units of 8 ns ticks and advances it once per reference clock cycle, scaled by a 32-bit fractional rate word. A rate word of 0x80000000 advances the count by exactly one tick per cycle. Larger or smaller words speed it up or slow it down in proportion. A phase accumulator carries the fractional remainder from cycle to cycle, so a trimmed rate produces an average step of rate/2^31 ticks per cycle. Each cycle therefore adds zero, one or two ticks.

Software reaches the block over a simple synchronous register bus with a two-bit word address, write and read strobes and 32-bit data. The control register holds an add-mode bit. With that bit clear, a 64-bit value write loads the count. With it set, the value is added to the count as a two's-complement offset. A value write is two 32-bit writes, low half first. A small write-path state machine has two states. From WP_IDLE, a low-half write moves it to WP_ARMED. From WP_ARMED, a high-half write commits the value and returns it to WP_IDLE. A further low-half write in WP_ARMED stays in WP_ARMED and replaces the staged half. A high-half write in WP_IDLE is dropped.

A valid control write with the zero bit set clears the count and the phase accumulator. Reading the low half of the time latches the high half, so the two halves always come from one instant. The live count is also driven on a port for timestamping logic nearby.

Top module: `phc_core`

## Requirements
- R1: After reset, time_now is 0, the rate register (address 1) reads 0x80000000 and the control register (address 0) reads 0.
- R2: At the nominal rate 0x80000000, time_now grows by exactly one per clock cycle.
- R3: The phase accumulator and the count are both zero right after a zero command. After that, with rate word R and no further writes, time_now k cycles later equals floor(k*R/2^31). Each cycle adds at most two ticks.
- R4: A write to the rate register (address 1) is clamped to the range [0x7BE76C8C, 0x84189374], which is nominal ±0x04189374 (about ±3.2%). Reading the register returns the clamped value.
- R5: When control bit 0 is 0, writing the low half (address 2) and then the high half (address 3) loads the count with {high, low}. The new value is on time_now one cycle after the high-half strobe and replaces that cycle's increment.
- R6: When control bit 0 is 1, the same two-write sequence adds the 64-bit two's-complement value to the count. The sum is on time_now one cycle after the high-half strobe and replaces that cycle's increment.
- R7: A high-half write (address 3) that does not follow a low-half write since the last commit is ignored, and the count keeps running.
- R8: A control write with bit 31 (valid) and bit 2 (zero) both set makes time_now 0 on the next cycle. Bit 2 always reads back as 0.
- R9: A control write with bit 31 clear is ignored. The control register keeps its value and the count is not cleared.
- R10: A valid control write stores bits 30..27 (schedule start, schedule stop, pin start, pin stop) and bits 1..0 (timestamp correction, add mode). The register reads back only those bits, and all other bits read 0.
- R11: A read strobe returns data on bus_rdata one cycle later. A low-half time read (address 2) returns the low 32 bits of the count at the strobe and latches the high 32 bits of that same count. A later high-half read (address 3) returns the latched high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one cycle is one nominal 8 ns tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word address: 0 control, 1 rate, 2 time low, 3 time high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| time_now | output | 64 | Live time count |

## Verification
The hardest case to reach is a coherent split read while the low half carries into the high half. The stimulus loads a count just below a 32-bit boundary and reads the low half right away. It then waits until the live count has crossed the boundary before it reads the high half, which must still show the pre-carry value. The fractional rate is checked exactly by clamping a rate to each trim limit and then issuing a zero command. That command puts the accumulator in a known state, so the expected count after many cycles can be computed in closed form.

// File: rtl/phc_pkg.sv
package phc_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_RATE = 2'd1,
        REG_TLO  = 2'd2,
        REG_THI  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        WP_IDLE  = 1'b0,
        WP_ARMED = 1'b1
    } wpath_e;

    // control word bit positions (software decodes these)
    localparam int CB_VALID   = 31;
    localparam int CB_SCHGO   = 30;
    localparam int CB_SCHHALT = 29;
    localparam int CB_PINGO   = 28;
    localparam int CB_PINHALT = 27;
    localparam int CB_ZERO    = 2;
    localparam int CB_TSCORR  = 1;
    localparam int CB_ADDMODE = 0;

    localparam logic [31:0] CTRL_KEEP_MASK =
        (32'd1 << CB_SCHGO) | (32'd1 << CB_SCHHALT) |
        (32'd1 << CB_PINGO) | (32'd1 << CB_PINHALT) |
        (32'd1 << CB_TSCORR) | (32'd1 << CB_ADDMODE);

endpackage

// File: rtl/phc_regs.sv
module phc_regs
    import phc_pkg::*;
#(
    parameter int          BUS_W     = 32,
    parameter int          RATE_W    = 32,
    parameter logic [31:0] RATE_TRIM = 32'h0418_9374,
    localparam int         TIME_W    = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_addr_e         addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [RATE_W-1:0] rate_word,
    output logic [BUS_W-1:0]  ctrl_word,
    output logic              zero_cmd,
    output logic              commit_en,
    output logic [TIME_W-1:0] commit_val,
    output logic              add_mode
);

    localparam logic [RATE_W-1:0] RATE_NOM = RATE_W'(1) << (RATE_W - 1);
    localparam logic [RATE_W-1:0] RATE_HI  = RATE_NOM + RATE_W'(RATE_TRIM);
    localparam logic [RATE_W-1:0] RATE_LO  = RATE_NOM - RATE_W'(RATE_TRIM);
    localparam logic [BUS_W-1:0]  KEEP     = BUS_W'(CTRL_KEEP_MASK);

    wpath_e             wp_state, wp_next;
    logic [BUS_W-1:0]   lo_stage;
    logic [RATE_W-1:0]  rate_in, rate_clamped;
    logic               ctrl_wr_ok;

    assign rate_in = wdata[RATE_W-1:0];

    always_comb begin
        if (rate_in > RATE_HI)
            rate_clamped = RATE_HI;
        else if (rate_in < RATE_LO)
            rate_clamped = RATE_LO;
        else
            rate_clamped = rate_in;
    end

    assign ctrl_wr_ok = wr && (addr == REG_CTRL) && wdata[CB_VALID];
    assign zero_cmd   = ctrl_wr_ok && wdata[CB_ZERO];
    assign add_mode   = ctrl_word[CB_ADDMODE];
    assign commit_val = {wdata, lo_stage};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wp_state <= WP_IDLE;
        else
            wp_state <= wp_next;
    end

    // transitions and outputs of the value write path
    always_comb begin
        wp_next   = wp_state;
        commit_en = 1'b0;
        unique case (wp_state)
            WP_IDLE: begin
                if (wr && addr == REG_TLO)
                    wp_next = WP_ARMED;
            end
            WP_ARMED: begin
                if (wr && addr == REG_THI) begin
                    wp_next   = WP_IDLE;
                    commit_en = 1'b1;
                end
            end
            default: wp_next = WP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_word <= RATE_NOM;
            ctrl_word <= '0;
            lo_stage  <= '0;
        end else begin
            if (wr && addr == REG_RATE)
                rate_word <= rate_clamped;
            if (ctrl_wr_ok)
                ctrl_word <= wdata & KEEP;
            if (wr && addr == REG_TLO)
                lo_stage <= wdata;
        end
    end

endmodule

// File: rtl/phc_rate_accum.sv
module phc_rate_accum #(
    parameter int RATE_W = 32,
    localparam int ACC_W = RATE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic [1:0]        inc
);

    logic [ACC_W-1:0] phase;
    logic [RATE_W:0]  sum;

    assign sum = {2'b00, phase} + {1'b0, rate};
    assign inc = sum[RATE_W:RATE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (clear)
            phase <= '0;
        else
            phase <= sum[ACC_W-1:0];
    end

endmodule

// File: rtl/phc_time_counter.sv
module phc_time_counter #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              commit_en,
    input  logic              add_mode,
    input  logic [TIME_W-1:0] commit_val,
    input  logic [1:0]        inc,
    output logic [TIME_W-1:0] time_q
);

    logic [TIME_W-1:0] time_d;

    always_comb begin
        if (clear)
            time_d = '0;
        else if (commit_en)
            time_d = add_mode ? (time_q + commit_val) : commit_val;
        else
            time_d = time_q + TIME_W'(inc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            time_q <= '0;
        else
            time_q <= time_d;
    end

endmodule

// File: rtl/phc_core.sv
module phc_core
    import phc_pkg::*;
#(
    parameter int          BUS_W     = 32,
    parameter int          RATE_W    = 32,
    parameter logic [31:0] RATE_TRIM = 32'h0418_9374,
    localparam int         TIME_W    = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [TIME_W-1:0] time_now
);

    reg_addr_e         addr_e;
    logic [RATE_W-1:0] rate_word;
    logic [BUS_W-1:0]  ctrl_word;
    logic              zero_cmd;
    logic              commit_en;
    logic [TIME_W-1:0] commit_val;
    logic              add_mode;
    logic [1:0]        inc;
    logic [BUS_W-1:0]  snap_hi;

    assign addr_e = reg_addr_e'(bus_addr);

    phc_regs #(
        .BUS_W     (BUS_W),
        .RATE_W    (RATE_W),
        .RATE_TRIM (RATE_TRIM)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .addr       (addr_e),
        .wdata      (bus_wdata),
        .rate_word  (rate_word),
        .ctrl_word  (ctrl_word),
        .zero_cmd   (zero_cmd),
        .commit_en  (commit_en),
        .commit_val (commit_val),
        .add_mode   (add_mode)
    );

    phc_rate_accum #(
        .RATE_W (RATE_W)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (zero_cmd),
        .rate  (rate_word),
        .inc   (inc)
    );

    phc_time_counter #(
        .TIME_W (TIME_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (zero_cmd),
        .commit_en  (commit_en),
        .add_mode   (add_mode),
        .commit_val (commit_val),
        .inc        (inc),
        .time_q     (time_now)
    );

    // registered read port with coherent high-half snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            snap_hi   <= '0;
        end else if (bus_rd) begin
            unique case (addr_e)
                REG_CTRL: bus_rdata <= ctrl_word;
                REG_RATE: bus_rdata <= BUS_W'(rate_word);
                REG_TLO: begin
                    bus_rdata <= time_now[BUS_W-1:0];
                    snap_hi   <= time_now[TIME_W-1:BUS_W];
                end
                REG_THI:  bus_rdata <= snap_hi;
                default:  bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/phc_core_chk.sv
module phc_core_chk #(
    parameter int          BUS_W     = 32,
    parameter int          RATE_W    = 32,
    parameter logic [31:0] RATE_TRIM = 32'h0418_9374,
    localparam int         TIME_W    = 2 * BUS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [TIME_W-1:0] time_now,
    input logic [RATE_W-1:0] rate_word,
    input logic [BUS_W-1:0]  ctrl_word,
    input logic              commit_en,
    input logic [TIME_W-1:0] commit_val,
    input logic              add_mode
);

    localparam logic [RATE_W-1:0] NOM = RATE_W'(1) << (RATE_W - 1);
    localparam logic [RATE_W-1:0] HI  = NOM + RATE_W'(RATE_TRIM);
    localparam logic [RATE_W-1:0] LO  = NOM - RATE_W'(RATE_TRIM);

    AST_RATE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_word >= LO) && (rate_word <= HI)); // R4

    AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd0) && !commit_en
        |=> (time_now - $past(time_now)) <= TIME_W'(2)); // R3

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en && !add_mode |=> time_now == $past(commit_val)); // R5

    AST_ADD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en && add_mode
        |=> time_now == $past(time_now) + $past(commit_val)); // R6

    AST_ZERO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 2'd0 && bus_wdata[31] && bus_wdata[2]
        |=> time_now == '0); // R8

    AST_INVALID_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 2'd0 && !bus_wdata[31]
        |=> $stable(ctrl_word)); // R9

    AST_CTRL_READ_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == 2'd0
        |=> !bus_rdata[31] && bus_rdata[26:2] == '0); // R10

    AST_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == 2'd2
        |=> bus_rdata == $past(time_now[BUS_W-1:0])); // R11

endmodule

bind phc_core phc_core_chk #(
    .BUS_W     (BUS_W),
    .RATE_W    (RATE_W),
    .RATE_TRIM (RATE_TRIM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .time_now   (time_now),
    .rate_word  (rate_word),
    .ctrl_word  (ctrl_word),
    .commit_en  (commit_en),
    .commit_val (commit_val),
    .add_mode   (add_mode)
);

// File: tb/phc_core_tb.sv
`timescale 1ns/1ps
module phc_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] time_now;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #5 clk = ~clk;

    phc_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .time_now  (time_now)
    );

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard queue
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: read with no expectation, actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d,
                             output logic [63:0] t_before);
        @(negedge clk);
        t_before  = time_now;
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic read_time_lo(input string tag, output logic [63:0] snap);
        @(negedge clk);
        snap = time_now;
        exp_q.push_back(snap[31:0]);
        tag_q.push_back(tag);
        bus_addr = 2'd2;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] t, snap, expv;
        logic [63:0] r64;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check64("R1 time after reset", time_now, 64'd0);
        bus_read(2'd1, 32'h8000_0000, "R1 rate reset value");
        bus_read(2'd0, 32'h0000_0000, "R1 ctrl reset value");

        // R2 nominal rate
        @(negedge clk);
        t = time_now;
        wait_cycles(10);
        check64("R2 nominal ten cycles", time_now, t + 64'd10);

        // R10 control readback mask
        bus_write(2'd0, 32'hFFFF_FFFB, t);
        bus_read(2'd0, 32'h7800_0003, "R10 ctrl stored bits");
        bus_write(2'd0, 32'h8000_0002, t);
        bus_read(2'd0, 32'h0000_0002, "R10 ctrl tscorr only");

        // R9 invalid control write ignored
        bus_write(2'd0, 32'h0000_0007, t);
        check64("R9 no clear on invalid ctrl", time_now, t + 64'd1);
        bus_read(2'd0, 32'h0000_0002, "R9 ctrl kept");

        // R8 zero command
        bus_write(2'd0, 32'h8000_0004, t);
        check64("R8 zero command", time_now, 64'd0);
        bus_read(2'd0, 32'h0000_0000, "R8 zero bit reads 0");
        @(negedge clk);
        t = time_now;
        wait_cycles(5);
        check64("R2 counting after zero", time_now, t + 64'd5);

        // R5 load mode
        bus_write(2'd0, 32'h8000_0000, t);
        bus_write(2'd2, 32'h89AB_CDEF, t);
        bus_write(2'd3, 32'h0123_4567, t);
        check64("R5 load value", time_now, 64'h0123_4567_89AB_CDEF);
        wait_cycles(3);
        check64("R5 continues after load", time_now, 64'h0123_4567_89AB_CDF2);

        // R7 lone high write ignored
        bus_write(2'd3, 32'hDEAD_BEEF, t);
        check64("R7 lone high write", time_now, t + 64'd1);

        // R6 add mode, positive and negative
        bus_write(2'd0, 32'h8000_0001, t);
        bus_write(2'd2, 32'h0000_1000, t);
        bus_write(2'd3, 32'h0000_0000, t);
        check64("R6 add positive", time_now, t + 64'h1000);
        bus_write(2'd2, 32'hFFFF_FF00, t);
        bus_write(2'd3, 32'hFFFF_FFFF, t);
        check64("R6 add negative", time_now, t - 64'd256);
        // R7 restage: second low write replaces first
        bus_write(2'd2, 32'h0000_0050, t);
        bus_write(2'd2, 32'h0000_0010, t);
        bus_write(2'd3, 32'h0000_0000, t);
        check64("R7 restaged low half", time_now, t + 64'h10);

        // R11 coherent split read across a carry
        bus_write(2'd0, 32'h8000_0000, t);
        bus_write(2'd2, 32'hFFFF_FFF0, t);
        bus_write(2'd3, 32'h0000_0005, t);
        read_time_lo("R11 low half", snap);
        wait_cycles(30);
        check64("R11 live high moved", {32'd0, time_now[63:32]}, 64'd6);
        bus_read(2'd3, snap[63:32], "R11 latched high half");

        // R4 clamp
        bus_write(2'd1, 32'hFFFF_FFFF, t);
        bus_read(2'd1, 32'h8418_9374, "R4 clamp high");
        bus_write(2'd1, 32'h0000_0001, t);
        bus_read(2'd1, 32'h7BE7_6C8C, "R4 clamp low");
        bus_write(2'd1, 32'h8000_1000, t);
        bus_read(2'd1, 32'h8000_1000, "R4 in range kept");

        // R3 fractional rate, fast limit
        bus_write(2'd1, 32'h8418_9374, t);
        bus_write(2'd0, 32'h8000_0004, t);
        check64("R3 zero before fast run", time_now, 64'd0);
        wait_cycles(1000);
        r64  = 64'h8418_9374;
        expv = (64'd1000 * r64) >> 31;
        check64("R3 fast rate count", time_now, expv);

        // R3 fractional rate, slow limit
        bus_write(2'd1, 32'h7BE7_6C8C, t);
        bus_write(2'd0, 32'h8000_0004, t);
        check64("R3 zero before slow run", time_now, 64'd0);
        wait_cycles(777);
        r64  = 64'h7BE7_6C8C;
        expv = (64'd777 * r64) >> 31;
        check64("R3 slow rate count", time_now, expv);

        wait_cycles(3);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule